// File: doc/BRIEF.md
# CAN Receive Buffer Acceptance Controller

This block sits between a CAN frame decoder and a single receive buffer. When the decoder signals that a frame is complete, the block applies the buffer's receive-mode rule to decide whether the frame may be stored. The rule looks at the frame's valid/error status, its identifier type, the acceptance-filter match result, and the identifier type that the matching filter expects. If the frame is accepted and the buffer is free, the block issues a load strobe to the buffer storage. It also latches the frame's remote-request flag and the index of the filter that hit.

The buffer is guarded by a sticky full flag. Hardware sets it on a load, and only a software write clears it. While it is set, any further acceptable frame is refused and reported on a drop pulse.

A mode input selects one of two register layouts, both seen through one 8-bit status/control register. In legacy operation, bits 6:5 hold a two-bit receive mode, bit 4 reads 0, bit 3 holds the remote flag and bits 2:0 hold the filter index. In enhanced operation, bit 6 holds a single receive-mode bit, bit 5 holds the remote flag and bits 4:0 hold the filter index. In both layouts, bit 7 is the full flag.

Top module: `rxacc_ctrl`

## Requirements
- R1: After a synchronous reset, `buf_full`, `rtr_flag`, `hit_idx`, `load_stb`, `drop_stb` and `reg_rdata` are all 0, and the receive mode is 0.
- R2: A frame accepted while the buffer is free gives a one-cycle `load_stb` after the clock edge that samples `frm_done`. `buf_full` reads 1 from that same edge on.
- R3: Writing bit 7 = 0 clears the full flag. Writing bit 7 = 1 leaves the flag unchanged and never sets it.
- R4: While the full flag is set, an acceptable frame is not loaded. `drop_stb` pulses instead, with the same timing as `load_stb`, and the stored remote flag and filter index keep their values.
- R5: Legacy mode, receive mode 2'b11: every completed frame is accepted, errored or not, matched or not, and the stored filter index is 0.
- R6: Legacy mode, receive mode 2'b10 accepts only valid, filter-matched frames with an extended identifier (`frm_ext`=1). Receive mode 2'b01 accepts only valid, filter-matched frames with a standard identifier (`frm_ext`=0).
- R7: Legacy mode, receive mode 2'b00 accepts a valid, filter-matched frame only when `frm_ext` equals the matched filter's expected identifier type `flt_ext_sel`.
- R8: Enhanced mode, receive bit (bit 6) = 1: every completed frame is accepted and the stored filter index is 0. Receive bit = 0: only valid, filter-matched frames are accepted, regardless of identifier type.
- R9: `rtr_flag` and `hit_idx` change only in the cycle of a load. Their new values are the frame's remote flag and the filter index, limited to 3 bits in legacy mode and 5 bits in enhanced mode.
- R10: Read layout: in legacy mode `reg_rdata` = {full, mode[1:0], 0, rtr, hit[2:0]}, so bit 4 is always 0. In enhanced mode `reg_rdata` = {full, mode[1], rtr, hit[4:0]}.
- R11: A clearing write and an acceptable frame in the same cycle load the frame, and the full flag stays 1.
- R12: A write in legacy mode stores bits 6:5 as the receive mode. A write in enhanced mode stores only bit 6 and leaves the low mode bit unchanged. Bits 4:0 of a write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_mode | input | 1 | 0 = legacy layout and rules, 1 = enhanced |
| frm_done | input | 1 | One-cycle strobe: a decoded frame is complete |
| frm_valid | input | 1 | Frame was received without error |
| frm_ext | input | 1 | Frame carries an extended identifier |
| frm_rtr | input | 1 | Frame is a remote transmission request |
| flt_match | input | 1 | An acceptance filter matched the identifier |
| flt_ext_sel | input | 1 | Identifier type expected by the matching filter (1 = extended) |
| flt_idx | input | 5 | Index of the matching filter |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read view, layout per `enh_mode` |
| buf_full | output | 1 | Buffer holds an unread frame |
| rtr_flag | output | 1 | Remote flag of the stored frame |
| hit_idx | output | 5 | Filter index of the stored frame |
| load_stb | output | 1 | One-cycle strobe to buffer storage: store the frame |
| drop_stb | output | 1 | One-cycle pulse: an acceptable frame was refused, buffer full |

## Verification
The assertions assume that `frm_done` is a single-cycle strobe whose flag inputs are stable in that cycle. They also assume that `enh_mode` does not change in the cycle before a load that is checked for a zero filter index. The stimulus drives every input on the falling clock edge and holds `enh_mode` constant through each sweep pass. It pulses `frm_done` for exactly one cycle per frame, with at least one idle cycle between frames. The sweep covers every mode code in both layouts against all 32 combinations of the validity, identifier-type, remote, match and filter-type flags.

// File: rtl/rxacc_pkg.sv
package rxacc_pkg;
  localparam int REG_W     = 8;
  localparam int HIT_W     = 5;
  localparam int LEG_HIT_W = 3;
  localparam int RM_W      = 2;
  // bit positions software decodes
  localparam int FULL_BIT  = 7;
  localparam int RM_HI_BIT = 6;
  localparam int RM_LO_BIT = 5;

  typedef enum logic {
    OP_LEGACY   = 1'b0,
    OP_ENHANCED = 1'b1
  } op_mode_e;

  typedef struct packed {
    logic             valid;
    logic             ext;
    logic             match;
    logic             ext_sel;
    logic [HIT_W-1:0] idx;
  } frame_t;
endpackage

// File: rtl/rxacc_rule.sv
module rxacc_rule
  import rxacc_pkg::*;
#(
  parameter int HW  = HIT_W,
  parameter int LHW = LEG_HIT_W
) (
  input  op_mode_e          op,
  input  logic [RM_W-1:0]   rmode,
  input  frame_t            frm,
  output logic              accept,
  output logic              accept_all,
  output logic [HW-1:0]     hit_val
);
  logic strict_ok;
  logic [HW-1:0] idx_lim;

  always_comb begin
    if (op == OP_ENHANCED) begin
      accept_all = rmode[1];
      strict_ok  = frm.match;
    end else begin
      accept_all = (rmode == 2'b11);
      unique case (rmode)
        2'b10:   strict_ok = frm.match & frm.ext;
        2'b01:   strict_ok = frm.match & ~frm.ext;
        default: strict_ok = frm.match & (frm.ext == frm.ext_sel);
      endcase
    end
    accept = accept_all | (frm.valid & strict_ok);
  end

  // legacy keeps only the low index bits
  for (genvar i = 0; i < HW; i++) begin : g_lim
    if (i < LHW) begin : g_keep
      assign idx_lim[i] = frm.idx[i];
    end else begin : g_gate
      assign idx_lim[i] = frm.idx[i] & (op == OP_ENHANCED);
    end
  end

  assign hit_val = accept_all ? '0 : idx_lim;
endmodule

// File: rtl/rxacc_status.sv
module rxacc_status
  import rxacc_pkg::*;
#(
  parameter int HW = HIT_W
) (
  input  logic            clk,
  input  logic            rst,
  input  op_mode_e        op,
  input  logic            wr,
  input  logic            wr_full,
  input  logic [RM_W-1:0] wr_rm,
  input  logic            done,
  input  logic            accept,
  input  logic            rtr_in,
  input  logic [HW-1:0]   hit_in,
  output logic            full_q,
  output logic [RM_W-1:0] rm_q,
  output logic            rtr_q,
  output logic [HW-1:0]   hit_q,
  output logic            load_q,
  output logic            drop_q
);
  logic clr, full_eff, take, miss;

  always_comb begin
    clr      = wr & ~wr_full;
    full_eff = full_q & ~clr;      // clear acts before the load
    take     = done & accept & ~full_eff;
    miss     = done & accept & full_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      rm_q   <= '0;
      rtr_q  <= 1'b0;
      hit_q  <= '0;
      load_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      load_q <= take;
      drop_q <= miss;
      full_q <= take | full_eff;
      if (wr) begin
        rm_q[1] <= wr_rm[1];
        if (op == OP_LEGACY) rm_q[0] <= wr_rm[0];
      end
      if (take) begin
        rtr_q <= rtr_in;
        hit_q <= hit_in;
      end
    end
  end
endmodule

// File: rtl/rxacc_regview.sv
module rxacc_regview
  import rxacc_pkg::*;
#(
  parameter int HW  = HIT_W,
  parameter int LHW = LEG_HIT_W
) (
  input  op_mode_e         op,
  input  logic             full,
  input  logic [RM_W-1:0]  rm,
  input  logic             rtr,
  input  logic [HW-1:0]    hit,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    if (op == OP_ENHANCED)
      rdata = {full, rm[1], rtr, hit};
    else
      rdata = {full, rm, 1'b0, rtr, hit[LHW-1:0]};
  end
endmodule

// File: rtl/rxacc_ctrl.sv
module rxacc_ctrl
  import rxacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enh_mode,
  input  logic             frm_done,
  input  logic             frm_valid,
  input  logic             frm_ext,
  input  logic             frm_rtr,
  input  logic             flt_match,
  input  logic             flt_ext_sel,
  input  logic [HIT_W-1:0] flt_idx,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             buf_full,
  output logic             rtr_flag,
  output logic [HIT_W-1:0] hit_idx,
  output logic             load_stb,
  output logic             drop_stb
);
  op_mode_e         op;
  frame_t           frm;
  logic             accept, accept_all;
  logic [HIT_W-1:0] hit_val;
  logic [RM_W-1:0]  rm_q;
  logic             unused_wbits;

  assign op  = enh_mode ? OP_ENHANCED : OP_LEGACY;
  assign frm = '{valid: frm_valid, ext: frm_ext, match: flt_match,
                 ext_sel: flt_ext_sel, idx: flt_idx};
  assign unused_wbits = ^reg_wdata[RM_LO_BIT-1:0];

  rxacc_rule #(.HW(HIT_W), .LHW(LEG_HIT_W)) u_rule (
    .op(op), .rmode(rm_q), .frm(frm),
    .accept(accept), .accept_all(accept_all), .hit_val(hit_val)
  );

  rxacc_status #(.HW(HIT_W)) u_stat (
    .clk(clk), .rst(rst), .op(op),
    .wr(reg_wr), .wr_full(reg_wdata[FULL_BIT]),
    .wr_rm(reg_wdata[RM_HI_BIT:RM_LO_BIT]),
    .done(frm_done), .accept(accept), .rtr_in(frm_rtr), .hit_in(hit_val),
    .full_q(buf_full), .rm_q(rm_q), .rtr_q(rtr_flag), .hit_q(hit_idx),
    .load_q(load_stb), .drop_q(drop_stb)
  );

  rxacc_regview #(.HW(HIT_W), .LHW(LEG_HIT_W)) u_view (
    .op(op), .full(buf_full), .rm(rm_q), .rtr(rtr_flag),
    .hit(hit_idx), .rdata(reg_rdata)
  );
endmodule

// File: rtl/rxacc_ctrl_chk.sv
module rxacc_ctrl_chk
  import rxacc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             enh_mode,
  input logic             reg_wr,
  input logic             wr_full_bit,
  input logic [REG_W-1:0] reg_rdata,
  input logic             buf_full,
  input logic             rtr_flag,
  input logic [HIT_W-1:0] hit_idx,
  input logic             load_stb,
  input logic             drop_stb
);
  assert_load_sets_full_R2: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> buf_full);

  assert_full_only_by_load_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> load_stb);

  assert_clear_drops_full_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_wr && !wr_full_bit) && !load_stb) |-> !buf_full);

  assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(buf_full) && !$past(reg_wr && !wr_full_bit)) |-> !load_stb);

  assert_load_drop_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(load_stb && drop_stb));

  assert_fields_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !load_stb |-> ($stable(rtr_flag) && $stable(hit_idx)));

  assert_acc_all_hit_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (load_stb && $past(enh_mode) == enh_mode &&
     $past(enh_mode ? reg_rdata[RM_HI_BIT]
                    : (reg_rdata[RM_HI_BIT] & reg_rdata[RM_LO_BIT]))) |-> hit_idx == '0);

  assert_legacy_bit4_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !enh_mode |-> !reg_rdata[4]);
endmodule

bind rxacc_ctrl rxacc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .enh_mode(enh_mode), .reg_wr(reg_wr),
  .wr_full_bit(reg_wdata[7]), .reg_rdata(reg_rdata), .buf_full(buf_full),
  .rtr_flag(rtr_flag), .hit_idx(hit_idx), .load_stb(load_stb), .drop_stb(drop_stb)
);

// File: tb/tb_rxacc_ctrl.sv
module tb_rxacc_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enh_mode = 1'b0, frm_done = 1'b0, frm_valid = 1'b0, frm_ext = 1'b0;
  logic       frm_rtr = 1'b0, flt_match = 1'b0, flt_ext_sel = 1'b0;
  logic [4:0] flt_idx = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       buf_full, rtr_flag, load_stb, drop_stb;
  logic [4:0] hit_idx;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [1:0] e_rm;
  logic       e_full, e_rtr;
  logic [4:0] e_hit;

  always #5 clk = ~clk;

  rxacc_ctrl dut (
    .clk(clk), .rst(rst), .enh_mode(enh_mode), .frm_done(frm_done),
    .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
    .flt_match(flt_match), .flt_ext_sel(flt_ext_sel), .flt_idx(flt_idx),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .buf_full(buf_full), .rtr_flag(rtr_flag), .hit_idx(hit_idx),
    .load_stb(load_stb), .drop_stb(drop_stb)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: returns at the next falling edge with strobes released
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    frm_done = 1'b0;
    reg_wr   = 1'b0;
  endtask

  function automatic logic [7:0] view(logic e, logic f, logic [1:0] rm, logic r, logic [4:0] h);
    return e ? {f, rm[1], r, h} : {f, rm, 1'b0, r, h[2:0]};
  endfunction

  function automatic logic acc_fn(logic e, logic [1:0] rm, logic v, logic x, logic m, logic s);
    if (e) return rm[1] | (v & m);
    case (rm)
      2'b11:   return 1'b1;
      2'b10:   return v & m & x;
      2'b01:   return v & m & ~x;
      default: return v & m & (x == s);
    endcase
  endfunction

  function automatic logic all_fn(logic e, logic [1:0] rm);
    return e ? rm[1] : (rm == 2'b11);
  endfunction

  task automatic write_reg(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    if (!d[7]) e_full = 1'b0;
    e_rm[1] = d[6];
    if (!enh_mode) e_rm[0] = d[5];
    cyc();
  endtask

  task automatic send(logic v, logic x, logic r, logic m, logic s, logic [4:0] i);
    frm_done = 1'b1; frm_valid = v; frm_ext = x; frm_rtr = r;
    flt_match = m; flt_ext_sel = s; flt_idx = i;
  endtask

  initial begin
    e_rm = '0; e_full = 0; e_rtr = 0; e_hit = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 outputs", {buf_full, rtr_flag, load_stb, drop_stb, hit_idx}, 8'h00);

    for (int e = 0; e < 2; e++) begin
      enh_mode = e[0];
      for (int c = 0; c < 4; c++) begin
        for (int f = 0; f < 32; f++) begin
          logic v, x, r, m, s, a, al;
          logic [4:0] idx;
          string tg;
          v = f[0]; x = f[1]; r = f[2]; m = f[3]; s = f[4];
          idx = 5'((f * 5 + c + 1) & 31);
          tg = e ? "R8" : (c == 3 ? "R5" : (c == 0 ? "R7" : "R6"));
          // clearing write that also sets the mode
          write_reg({1'b0, c[1:0], 5'b0});
          check("R3 clear", {7'b0, buf_full}, {7'b0, e_full});
          check("R10 view", reg_rdata, view(e[0], e_full, e_rm, e_rtr, e_hit));
          // the frame under test
          send(v, x, r, m, s, idx);
          cyc();
          a  = acc_fn(e[0], e_rm, v, x, m, s);
          al = all_fn(e[0], e_rm);
          check({tg, " accept"}, {6'b0, load_stb, buf_full}, {6'b0, a, a});
          check("R2 no drop", {7'b0, drop_stb}, 8'h00);
          if (a) begin
            e_full = 1'b1; e_rtr = r;
            e_hit = al ? 5'd0 : (e ? idx : {2'b00, idx[2:0]});
          end
          check("R9 fields", {2'b0, rtr_flag, hit_idx}, {2'b0, e_rtr, e_hit});
          check("R10 view", reg_rdata, view(e[0], e_full, e_rm, e_rtr, e_hit));
          if (a) begin
            // second acceptable frame while full
            send(v, x, ~r, m, s, idx + 5'd1);
            cyc();
            check("R4 blocked", {6'b0, load_stb, drop_stb}, 8'h01);
            check("R4 fields kept", reg_rdata, view(e[0], 1'b1, e_rm, e_rtr, e_hit));
            // write with bit 7 = 1 keeps full
            write_reg({1'b1, c[1:0], 5'b0});
            check("R3 write1 keeps", {7'b0, buf_full}, 8'h01);
          end else begin
            write_reg({1'b1, c[1:0], 5'b0});
            check("R3 write1 no set", {7'b0, buf_full}, 8'h00);
          end
        end
      end
    end

    // R11: clear and accept-all frame in the same cycle
    enh_mode = 1'b0;
    write_reg(8'h60);
    send(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3);
    cyc();
    check("R11 first load", {7'b0, buf_full}, 8'h01);
    e_full = 1'b1; e_rtr = 1'b1; e_hit = '0;
    reg_wr = 1'b1; reg_wdata = 8'h60;
    send(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd6);
    cyc();
    e_rtr = 1'b0;
    check("R11 full kept", {6'b0, load_stb, buf_full}, 8'h03);
    check("R11 fields", reg_rdata, view(1'b0, 1'b1, 2'b11, 1'b0, 5'd0));

    // R12: enhanced write leaves low mode bit; bits 4:0 ignored
    write_reg(8'h3F);   // legacy: mode 01, full cleared
    check("R12 legacy write", reg_rdata & 8'hF0, 8'h20);
    enh_mode = 1'b1;
    write_reg(8'h40);
    check("R12 enh bit6", reg_rdata[7:6], 2'b01);
    enh_mode = 1'b0;
    @(negedge clk);
    check("R12 low bit kept", reg_rdata & 8'hF0, 8'h60);
    write_reg(8'h1F);
    check("R12 bits4:0 ignored", reg_rdata & 8'hF0, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule